// File: doc/BRIEF.md
# Coprocessor Conditional Loop Sequencer

This block carries out the main-processor half of a decrement-and-branch instruction whose loop condition is decided by an attached coprocessor. It takes an operation word that has already been fetched, a condition-selector word, a 16-bit displacement and the address of that displacement word. It writes the selector to the coprocessor's condition register over a small request/acknowledge register bus. It then polls the coprocessor's response register until it gets a verdict.

A true verdict ends the instruction with no branch. A false verdict decrements the low 16 bits of the data register named by the operation word, through a register-file port. The branch is taken unless the decremented low word wraps to all ones. The block reports the next program counter, a taken flag and an error flag with a single-cycle completion pulse.

Top module: `ccl_loop_seq`

## Requirements
- R1: The first bus transaction after `start` is a write (`cp_we`=1) of the latched `cond_sel` value to register offset `COND_ADDR`.
- R2: After that write is acknowledged, the block reads offset `RESP_ADDR`. It keeps reading while the response code in `cp_rdata[1:0]` is 00 (busy or service request).
- R3: Code 10 (true) completes with `taken`=0, `next_pc`=`scan_pc`+2, `error`=0, and no register-file write.
- R4: Code 01 (false) writes back the register selected by `op_word[2:0]` once. The low 16 bits are decremented by one and the upper 16 bits are unchanged.
- R5: On a false verdict where the decremented low word is 16'hFFFF, the block completes with `taken`=0 and `next_pc`=`scan_pc`+2.
- R6: On any other false verdict, the block completes with `taken`=1 and `next_pc`=`scan_pc` plus the sign-extended `disp`. Displacements may be negative.
- R7: Code 11 completes with `error`=1 and `taken`=0, and no register is written.
- R8: `done` is high for exactly one cycle per sequence. `taken`, `error` and `next_pc` hold their values after it.
- R9: Only one bus transaction is outstanding at a time. While `cp_req` is high without `cp_ack`, the request and its `cp_we`, `cp_addr` and `cp_wdata` stay stable.
- R10: A synchronous active-low reset returns the block to idle with `cp_req`, `rf_we` and `done` low. This holds even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a sequence when idle |
| op_word | input | 16 | Operation word; bits 2..0 select the data register |
| cond_sel | input | CIR_DW | Condition-selector word |
| disp | input | DISP_W | Two's-complement displacement |
| scan_pc | input | ADDR_W | Address of the displacement word |
| cp_req | output | 1 | Bus request |
| cp_we | output | 1 | 1 = write, 0 = read |
| cp_addr | output | CIR_AW | Coprocessor register offset |
| cp_wdata | output | CIR_DW | Write data |
| cp_ack | input | 1 | Bus acknowledge |
| cp_rdata | input | CIR_DW | Read data, valid with `cp_ack` |
| rf_sel | output | 3 | Register-file index |
| rf_rdata | input | DATA_W | Selected register contents |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | DATA_W | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| error | output | 1 | Protocol violation |
| next_pc | output | ADDR_W | Address of the next instruction |

## Verification
The bench overrides the register offsets, using 3 for the condition register and 17 for the response register, so that address decoding cannot pass by coinciding with the defaults. The widths stay at 32-bit data and addresses with a 16-bit loop word and displacement. With a 16-bit low word, the wrap at zero, a negative displacement and an upper half full of ones are all cheap to set up. The bench's coprocessor model varies its acknowledge latency from zero to three wait cycles and inserts busy responses, which exercises held requests and back-to-back polls.

// File: rtl/ccl_pkg.sv
// Shared types for the coprocessor conditional loop sequencer.
// Assumes a 2-bit response code in the low bits of the response register.
package ccl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_POLL,
        ST_DEC,
        ST_DONE
    } ccl_state_e;

    typedef enum logic [1:0] {
        RSP_BUSY  = 2'b00,
        RSP_FALSE = 2'b01,
        RSP_TRUE  = 2'b10,
        RSP_BAD   = 2'b11
    } ccl_rsp_e;
endpackage

// File: rtl/ccl_counter.sv
// Loop counter update: decrements only the low LOOP_W bits of a register
// and flags when the result wraps to all ones. Purely combinational.
// Assumes LOOP_W <= DATA_W.
module ccl_counter #(
    parameter int DATA_W = 32,
    parameter int LOOP_W = 16
) (
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] nxt,
    output logic              expired
);
    logic [LOOP_W-1:0] low_dec;

    // Decrement the low loop word.
    assign low_dec = cur[LOOP_W-1:0] - LOOP_W'(1);
    // Wrap to minus one ends the loop.
    assign expired = &low_dec;

    generate
        if (DATA_W > LOOP_W) begin : g_keep_upper
            assign nxt = {cur[DATA_W-1:LOOP_W], low_dec};
        end else begin : g_full
            assign nxt = low_dec;
        end
    endgenerate
endmodule

// File: rtl/ccl_target.sv
// Address generation: fall-through address and branch target relative
// to the address of the displacement word. Purely combinational.
// Assumes DISP_W < ADDR_W.
module ccl_target #(
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic [ADDR_W-1:0] scan_pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] branch_pc
);
    localparam int EXT_W = ADDR_W - DISP_W;
    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend the displacement to address width.
    assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
    // Next sequential instruction follows the displacement word.
    assign fall_pc   = scan_pc + ADDR_W'(WORD_BYTES);
    // Branch target is relative to the displacement word.
    assign branch_pc = scan_pc + disp_ext;
endmodule

// File: rtl/ccl_loop_seq.sv
// Main-processor sequencer for a coprocessor-conditioned decrement-and-branch.
// Writes the selector, polls the response, optionally decrements a data
// register and produces next_pc/taken/error with a one-cycle done pulse.
// Assumes an asynchronous-read register file and a bus slave that returns
// read data in the acknowledge cycle.
module ccl_loop_seq
    import ccl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LOOP_W = 16,
    parameter int DISP_W = 16,
    parameter int CIR_AW = 5,
    parameter int CIR_DW = 16,
    parameter logic [CIR_AW-1:0] COND_ADDR = 5'h0E,
    parameter logic [CIR_AW-1:0] RESP_ADDR = 5'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       op_word,
    input  logic [CIR_DW-1:0] cond_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] scan_pc,
    output logic              cp_req,
    output logic              cp_we,
    output logic [CIR_AW-1:0] cp_addr,
    output logic [CIR_DW-1:0] cp_wdata,
    input  logic              cp_ack,
    input  logic [CIR_DW-1:0] cp_rdata,
    output logic [2:0]        rf_sel,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              done,
    output logic              taken,
    output logic              error,
    output logic [ADDR_W-1:0] next_pc
);
    ccl_state_e        state_q, state_d;
    logic [CIR_DW-1:0] sel_q;
    logic [DISP_W-1:0] disp_q;
    logic [ADDR_W-1:0] pc_q;
    logic [2:0]        reg_q;
    logic              taken_q, err_q;
    logic [ADDR_W-1:0] npc_q;
    logic [1:0]        rsp;
    logic              expired;
    logic [ADDR_W-1:0] fall_pc, branch_pc;
    logic              unused_bits;

    assign rsp         = cp_rdata[1:0];
    assign unused_bits = ^{op_word[15:3], cp_rdata[CIR_DW-1:2]};

    ccl_counter #(.DATA_W(DATA_W), .LOOP_W(LOOP_W)) u_counter (
        .cur     (rf_rdata),
        .nxt     (rf_wdata),
        .expired (expired)
    );

    ccl_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .WORD_BYTES(2)) u_target (
        .scan_pc   (pc_q),
        .disp      (disp_q),
        .fall_pc   (fall_pc),
        .branch_pc (branch_pc)
    );

    // Sequence control: selector write, response polling, decrement, finish.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (cp_ack) state_d = ST_POLL;
            ST_POLL: if (cp_ack) begin
                unique case (rsp)
                    RSP_BUSY:  state_d = ST_POLL;
                    RSP_FALSE: state_d = ST_DEC;
                    default:   state_d = ST_DONE;
                endcase
            end
            ST_DEC:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the instruction operands when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            disp_q <= '0;
            pc_q   <= '0;
            reg_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            sel_q  <= cond_sel;
            disp_q <= disp;
            pc_q   <= scan_pc;
            reg_q  <= op_word[2:0];
        end
    end

    // Record the outcome; values hold until the next outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            err_q   <= 1'b0;
            npc_q   <= '0;
        end else if (state_q == ST_POLL && cp_ack && rsp != RSP_BUSY && rsp != RSP_FALSE) begin
            taken_q <= 1'b0;
            err_q   <= (rsp == RSP_BAD);
            npc_q   <= fall_pc;
        end else if (state_q == ST_DEC) begin
            taken_q <= ~expired;
            err_q   <= 1'b0;
            npc_q   <= expired ? fall_pc : branch_pc;
        end
    end

    // Bus request fields derived from the current state.
    always_comb begin
        cp_req   = (state_q == ST_SEND) || (state_q == ST_POLL);
        cp_we    = (state_q == ST_SEND);
        cp_addr  = (state_q == ST_SEND) ? COND_ADDR : RESP_ADDR;
        cp_wdata = sel_q;
    end

    assign rf_sel  = reg_q;
    assign rf_we   = (state_q == ST_DEC);
    assign done    = (state_q == ST_DONE);
    assign taken   = taken_q;
    assign error   = err_q;
    assign next_pc = npc_q;
endmodule

// File: rtl/ccl_loop_seq_chk.sv
// Protocol checker for ccl_loop_seq, attached by bind. Observes ports only.
module ccl_loop_seq_chk #(
    parameter int DATA_W = 32,
    parameter int CIR_AW = 5,
    parameter int CIR_DW = 16,
    parameter int LOOP_W = 16,
    parameter logic [CIR_AW-1:0] COND_ADDR = 5'h0E,
    parameter logic [CIR_AW-1:0] RESP_ADDR = 5'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cp_req,
    input logic              cp_we,
    input logic [CIR_AW-1:0] cp_addr,
    input logic [CIR_DW-1:0] cp_wdata,
    input logic              cp_ack,
    input logic [DATA_W-1:0] rf_rdata,
    input logic              rf_we,
    input logic [DATA_W-1:0] rf_wdata,
    input logic              done,
    input logic              taken,
    input logic              error
);
    p_sel_write_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cp_req && cp_we |-> cp_addr == COND_ADDR);

    p_write_then_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cp_req && cp_we && cp_ack |=> cp_req && !cp_we && cp_addr == RESP_ADDR);

    p_upper_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wdata[DATA_W-1:LOOP_W] == rf_rdata[DATA_W-1:LOOP_W]
                  && rf_wdata[LOOP_W-1:0] == rf_rdata[LOOP_W-1:0] - LOOP_W'(1));

    p_write_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> done && !error);

    p_err_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && error |-> !taken && !$past(rf_we));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cp_req && !cp_ack |=> cp_req && $stable(cp_we) && $stable(cp_addr) && $stable(cp_wdata));

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> !cp_req && !rf_we && !done);
endmodule

bind ccl_loop_seq ccl_loop_seq_chk #(
    .DATA_W(DATA_W), .CIR_AW(CIR_AW), .CIR_DW(CIR_DW), .LOOP_W(LOOP_W),
    .COND_ADDR(COND_ADDR), .RESP_ADDR(RESP_ADDR)
) u_chk (.*);

// File: tb/ccl_loop_seq_tb.sv
`timescale 1ns/1ps
module ccl_loop_seq_tb;
    localparam logic [4:0] COND = 5'd3;
    localparam logic [4:0] RESP = 5'd17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op_word = '0;
    logic [15:0] cond_sel = '0;
    logic [15:0] disp = '0;
    logic [31:0] scan_pc = '0;
    logic        cp_req, cp_we, cp_ack;
    logic [4:0]  cp_addr;
    logic [15:0] cp_wdata, cp_rdata;
    logic [2:0]  rf_sel;
    logic [31:0] rf_rdata, rf_wdata, next_pc;
    logic        rf_we, done, taken, error;

    always #2.5 clk = ~clk;

    ccl_loop_seq #(.COND_ADDR(COND), .RESP_ADDR(RESP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
        .cond_sel(cond_sel), .disp(disp), .scan_pc(scan_pc),
        .cp_req(cp_req), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_ack(cp_ack), .cp_rdata(cp_rdata), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .done(done), .taken(taken),
        .error(error), .next_pc(next_pc)
    );

    // Register-file model with asynchronous read.
    logic [31:0] rf [8];
    int          n_rfw = 0;
    assign rf_rdata = rf[rf_sel];
    always @(posedge clk) if (rf_we) begin
        rf[rf_sel] = rf_wdata;
        n_rfw = n_rfw + 1;
    end

    // Coprocessor model: acknowledges after lat wait cycles, returns queued codes.
    logic [1:0]  resp_q [256];
    int          lat = 0, wait_c = 0, ridx = 0, n_wr = 0, n_rd = 0, bad_rd = 0;
    logic [15:0] sel_seen = '0;
    logic [4:0]  wr_addr = '0;
    initial cp_ack = 1'b0;
    initial cp_rdata = '0;
    always @(posedge clk) begin
        cp_ack <= 1'b0;
        if (cp_req && !cp_ack) begin
            if (wait_c >= lat) begin
                cp_ack <= 1'b1;
                wait_c <= 0;
                if (cp_we) begin
                    sel_seen <= cp_wdata;
                    wr_addr  <= cp_addr;
                    n_wr     <= n_wr + 1;
                end else begin
                    cp_rdata <= {14'h2A5, resp_q[ridx[7:0]]};
                    ridx     <= ridx + 1;
                    n_rd     <= n_rd + 1;
                    if (cp_addr != RESP) bad_rd <= bad_rd + 1;
                end
            end else begin
                wait_c <= wait_c + 1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Results of the last run.
    logic        g_taken, g_err, g_pulse, g_hold;
    logic [31:0] g_pc;
    int          d_wr, d_rd, d_rfw;

    task automatic run_seq(input int ri, input logic [31:0] rv, input logic [15:0] d,
                           input logic [31:0] pc, input logic [1:0] c0, input logic [1:0] c1,
                           input logic [1:0] c2, input int nr, input int l);
        int b_wr, b_rd, b_rfw;
        bit got;
        @(negedge clk);
        lat = l;
        resp_q[(ridx + 0) % 256] = c0;
        resp_q[(ridx + 1) % 256] = c1;
        resp_q[(ridx + 2) % 256] = c2;
        b_wr = n_wr; b_rd = n_rd; b_rfw = n_rfw;
        rf[ri] = rv;
        op_word  = {4'hF, 3'd1, 6'b001001, 3'(ri)};
        cond_sel = 16'hC300 + 16'(ri);
        disp = d; scan_pc = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, "R8 done seen", 32'(got), 32'd1);
        g_taken = taken; g_err = error; g_pc = next_pc;
        @(negedge clk);
        g_pulse = !done;
        g_hold  = (taken == g_taken) && (error == g_err) && (next_pc == g_pc);
        d_wr = n_wr - b_wr; d_rd = n_rd - b_rd; d_rfw = n_rfw - b_rfw;
        chk(d_wr == 1 && sel_seen == 16'hC300 + 16'(ri) && wr_addr == COND, "R1 selector write",
            {wr_addr, 11'(d_wr), sel_seen}, {COND, 11'd1, 16'hC300 + 16'(ri)});
        chk(d_rd == nr && bad_rd == 0, "R2 response reads", 32'(d_rd), 32'(nr));
        chk(g_pulse && g_hold, "R8 single pulse and hold", {30'd0, g_pulse, g_hold}, 32'd3);
        nr = nr;
    endtask

    task automatic t_reset_state();
        chk(!cp_req && !rf_we && !done && !taken && !error, "R10 reset state",
            {27'd0, cp_req, rf_we, done, taken, error}, 32'd0);
    endtask

    task automatic t_true_verdict();
        run_seq(2, 32'h0000_0009, 16'h0040, 32'h0000_1000, 2'b10, 2'b00, 2'b00, 1, 0);
        chk(!g_taken && !g_err && g_pc == 32'h1002, "R3 true next_pc", g_pc, 32'h1002);
        chk(d_rfw == 0 && rf[2] == 32'h9, "R3 no write", rf[2], 32'h9);
    endtask

    task automatic t_false_taken();
        run_seq(5, 32'h1234_0005, 16'h0100, 32'h0000_2000, 2'b00, 2'b00, 2'b01, 3, 2);
        chk(d_rfw == 1 && rf[5] == 32'h1234_0004, "R4 low decrement", rf[5], 32'h1234_0004);
        chk(g_taken && g_pc == 32'h2100, "R6 branch target", g_pc, 32'h2100);
    endtask

    task automatic t_false_expire();
        run_seq(7, 32'hFFFF_0000, 16'h0100, 32'h0000_3000, 2'b01, 2'b00, 2'b00, 1, 1);
        chk(rf[7] == 32'hFFFF_FFFF, "R4 upper kept on wrap", rf[7], 32'hFFFF_FFFF);
        chk(!g_taken && g_pc == 32'h3002, "R5 fall through on wrap", g_pc, 32'h3002);
    endtask

    task automatic t_negative_disp();
        run_seq(0, 32'hABCD_0001, 16'hFFF0, 32'h0000_4000, 2'b00, 2'b01, 2'b00, 2, 3);
        chk(rf[0] == 32'hABCD_0000, "R4 reaches zero", rf[0], 32'hABCD_0000);
        chk(g_taken && g_pc == 32'h3FF0, "R6 negative displacement", g_pc, 32'h3FF0);
    endtask

    task automatic t_protocol_error();
        run_seq(3, 32'h0000_0002, 16'h0010, 32'h0000_5000, 2'b00, 2'b11, 2'b00, 2, 0);
        chk(g_err && !g_taken, "R7 error flag", {30'd0, g_err, g_taken}, 32'd2);
        chk(d_rfw == 0 && rf[3] == 32'h2, "R7 register untouched", rf[3], 32'h2);
    endtask

    task automatic t_reset_midway();
        @(negedge clk);
        lat = 1;
        for (int i = 0; i < 32; i++) resp_q[(ridx + i) % 256] = 2'b00;
        op_word = 16'hF24C; cond_sel = 16'h1111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk(cp_req, "R2 polling while busy", 32'(cp_req), 32'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!cp_req && !rf_we && !done, "R10 reset mid-sequence",
            {29'd0, cp_req, rf_we, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cp_req, "R10 stays idle after reset", 32'(cp_req), 32'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_true_verdict();
        t_false_taken();
        t_false_expire();
        t_negative_disp();
        t_protocol_error();
        t_reset_midway();
        t_false_taken();
        summary();
    end
endmodule